// File: doc/BRIEF.md
# Backplane Frame Pulse Generator

This block produces the frame pulse that marks the framing-bit position on a receive backplane. The frame counter divides the backplane clock by 193 for a 1.544 MHz backplane or by 256 for a 2.048 MHz backplane. An external frame-sync input can move the counter to a new position without a glitch. With the sync input held low, the counter runs freely. With its own output wired back to the sync input, the pulse stays where it is.

A second divider can thin the frame pulses to one per superframe, either every 12 frames or every 24 frames. A doubling option halves the pulse rate again, which serves superframe interworking between the two formats. The external sync never touches this second divider. A pass-through mode takes a frame pulse that is already timed by the recovered line clock and sends it out, still through the superframe divider. In that mode the frame counter and the sync input play no part.

Top module: `bpfp_gen`

## Requirements
- R1: With `rate_hi_i`=0 latched, frame boundaries recur every 193 clocks, and with no superframe thinning `fp_o` pulses every 193 clocks.
- R2: With `rate_hi_i`=1 latched, frame boundaries recur every 256 clocks.
- R3: Outside pass-through, if `sync_i` is high in clock cycle t, the next frame boundary puts `fp_o` high in cycle t+N, where N is the current frame length. Any boundary already due in cycle t+1 still happens.
- R4: When `fp_o` is wired back to `sync_i`, the pulse keeps the same period and the same position relative to the clock.
- R5: While `rst_ni` is low, `fp_o` is 0 and both counters are cleared. The first pulse appears in the cycle after the 193rd rising clock edge that follows reset release.
- R6: With `sf_en_i`=1, a pulse is emitted on one frame boundary in 12 when `esf_i`=0 and in 24 when `esf_i`=1.
- R7: `dbl_i`=1 doubles the number of frame boundaries between pulses: 2 with superframe off, 24 for `esf_i`=0 and 48 for `esf_i`=1.
- R8: `sync_i` does not touch the superframe divider. After a sync inside a superframe, the next pulse still comes on the boundary that completes the count.
- R9: With `bypass_i`=1, `sync_i` and the frame counter are ignored. Each `byp_fp_i` pulse is a frame boundary, and `fp_o` follows it one clock later, subject to R6 and R7.
- R10: The four mode bits `rate_hi_i`, `sf_en_i`, `esf_i` and `dbl_i` are sampled only on a frame boundary and govern the following frame. After reset they act as all zero until the first boundary.
- R11: Outside pass-through, `fp_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Backplane clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | External frame sync; high marks the framing-bit cycle |
| rate_hi_i | input | 1 | 0: 193-clock frame, 1: 256-clock frame |
| sf_en_i | input | 1 | Superframe thinning enable |
| esf_i | input | 1 | Superframe length: 0 gives 12 frames, 1 gives 24 frames |
| dbl_i | input | 1 | Double the pulse period |
| bypass_i | input | 1 | Pass-through of the recovered-clock frame pulse |
| byp_fp_i | input | 1 | Frame pulse timed by the recovered line clock |
| fp_o | output | 1 | Frame or superframe pulse, one clock wide |

## Verification
If the frame counter holds a wrong value, the next pulse moves or the gap between pulses changes. That shows within one frame, at most 256 clocks. If the superframe count is wrong, a pulse goes missing or appears extra, which shows within one superframe, at most 48 frames. A wrongly latched mode shows at the first boundary after the latch. The bench compares `fp_o` every cycle against a model written from the requirements. It also measures pulse spacing directly after resets, syncs, mode changes and pass-through pulses.

// File: rtl/bpfp_pkg.sv
package bpfp_pkg;

    typedef struct packed {
        logic rate_hi;
        logic sf_en;
        logic esf;
        logic dbl;
    } bpfp_mode_t;

    localparam bpfp_mode_t MODE_RESET = '{rate_hi: 1'b0, sf_en: 1'b0, esf: 1'b0, dbl: 1'b0};

    typedef struct packed {
        bpfp_mode_t mode;
        logic       pulse;
    } bpfp_out_state_t;

endpackage

// File: rtl/bpfp_frame_ctr.sv
module bpfp_frame_ctr #(
    parameter  int DIV_LO = 193,
    parameter  int DIV_HI = 256,
    localparam int CNT_W  = $clog2(DIV_HI)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hold_i,
    input  logic             sync_i,
    input  logic             rate_hi_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(DIV_LO - 1);
    localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(DIV_HI - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t       st_d, st_q;
    logic [CNT_W-1:0] last_pos;
    logic             at_end;

    always_comb begin
        last_pos = rate_hi_i ? LAST_HI : LAST_LO;
        at_end   = !hold_i && (st_q.cnt >= last_pos);
        st_d     = st_q;
        if (hold_i) begin
            st_d.cnt = '0;
        end else if (sync_i) begin
            // the sync cycle itself is position 0
            st_d.cnt = CNT_W'(1);
        end else if (at_end) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign wrap_o = at_end;

endmodule

// File: rtl/bpfp_sf_div.sv
module bpfp_sf_div
    import bpfp_pkg::*;
#(
    parameter  int SF_FRAMES  = 12,
    parameter  int ESF_FRAMES = 24,
    localparam int SF_MAX     = (ESF_FRAMES > SF_FRAMES) ? ESF_FRAMES : SF_FRAMES,
    localparam int SF_W       = $clog2(2 * SF_MAX)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            tick_i,
    input  bpfp_mode_t      mode_i,
    output logic            open_o,
    output logic [SF_W-1:0] cnt_o
);

    typedef struct packed {
        logic [SF_W-1:0] cnt;
    } sf_state_t;

    sf_state_t       st_d, st_q;
    int              base_len;
    int              full_len;
    logic [SF_W-1:0] top_val;

    always_comb begin
        base_len = mode_i.sf_en ? (mode_i.esf ? ESF_FRAMES : SF_FRAMES) : 1;
        full_len = mode_i.dbl ? 2 * base_len : base_len;
        top_val  = SF_W'(full_len - 1);
        st_d     = st_q;
        if (tick_i) begin
            // >= so that a shorter length after a mode change wraps at once
            if (st_q.cnt >= top_val) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign open_o = (st_q.cnt == '0);
    assign cnt_o  = st_q.cnt;

endmodule

// File: rtl/bpfp_gen.sv
module bpfp_gen
    import bpfp_pkg::*;
#(
    parameter int DIV_LO     = 193,
    parameter int DIV_HI     = 256,
    parameter int SF_FRAMES  = 12,
    parameter int ESF_FRAMES = 24
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sync_i,
    input  logic rate_hi_i,
    input  logic sf_en_i,
    input  logic esf_i,
    input  logic dbl_i,
    input  logic bypass_i,
    input  logic byp_fp_i,
    output logic fp_o
);

    localparam int CNT_W  = $clog2(DIV_HI);
    localparam int SF_MAX = (ESF_FRAMES > SF_FRAMES) ? ESF_FRAMES : SF_FRAMES;
    localparam int SF_W   = $clog2(2 * SF_MAX);

    bpfp_out_state_t  st_d, st_q;
    bpfp_mode_t       mode_in;
    logic [CNT_W-1:0] frame_cnt;
    logic             frame_wrap;
    logic             frame_tick;
    logic [SF_W-1:0]  sf_cnt;
    logic             sf_open;

    bpfp_frame_ctr #(
        .DIV_LO (DIV_LO),
        .DIV_HI (DIV_HI)
    ) u_frame_ctr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .hold_i    (bypass_i),
        .sync_i    (sync_i),
        .rate_hi_i (st_q.mode.rate_hi),
        .cnt_o     (frame_cnt),
        .wrap_o    (frame_wrap)
    );

    bpfp_sf_div #(
        .SF_FRAMES  (SF_FRAMES),
        .ESF_FRAMES (ESF_FRAMES)
    ) u_sf_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (frame_tick),
        .mode_i (st_q.mode),
        .open_o (sf_open),
        .cnt_o  (sf_cnt)
    );

    always_comb begin
        mode_in    = '{rate_hi: rate_hi_i, sf_en: sf_en_i, esf: esf_i, dbl: dbl_i};
        frame_tick = bypass_i ? byp_fp_i : frame_wrap;
        st_d       = st_q;
        if (frame_tick) begin
            st_d.mode = mode_in;
        end
        st_d.pulse = frame_tick && sf_open;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.mode  <= MODE_RESET;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fp_o = st_q.pulse;

endmodule

// File: rtl/bpfp_chk.sv
module bpfp_chk
    import bpfp_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int SF_W   = 6,
    parameter int DIV_LO = 193
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             sync_i,
    input logic             bypass_i,
    input logic             byp_fp_i,
    input logic             fp_o,
    input logic             frame_tick,
    input logic [CNT_W-1:0] frame_cnt,
    input logic [SF_W-1:0]  sf_cnt,
    input bpfp_mode_t       mode_q
);

    // R1: the short frame never reaches positions beyond its last bit
    assert_frame_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mode_q.rate_hi |-> (frame_cnt <= CNT_W'(DIV_LO - 1)));

    // R3: a sync outside pass-through restarts the frame grid
    assert_sync_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sync_i && !bypass_i) |=> (frame_cnt == CNT_W'(1)));

    // R8: the superframe count moves only on frame boundaries, never on a sync
    assert_sf_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !frame_tick |=> $stable(sf_cnt));

    // R9: in pass-through, no input pulse means no output pulse
    assert_bypass_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bypass_i && !byp_fp_i) |=> !fp_o);

    // R10: mode bits change only on a frame boundary
    assert_mode_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !frame_tick |=> $stable(mode_q));

    // R11: pulses are a single clock wide outside pass-through
    assert_single_width_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fp_o && !bypass_i) |=> !fp_o);

endmodule

bind bpfp_gen bpfp_chk #(
    .CNT_W  (CNT_W),
    .SF_W   (SF_W),
    .DIV_LO (DIV_LO)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (sync_i),
    .bypass_i   (bypass_i),
    .byp_fp_i   (byp_fp_i),
    .fp_o       (fp_o),
    .frame_tick (frame_tick),
    .frame_cnt  (frame_cnt),
    .sf_cnt     (sf_cnt),
    .mode_q     (st_q.mode)
);

// File: tb/bpfp_gen_tb.sv
module bpfp_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic clk = 1'b0;
    logic rst_n, sync_in, rate_hi, sf_en, esf, dbl, bypass, byp_fp;
    logic fp;

    bpfp_gen u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .sync_i    (sync_in),
        .rate_hi_i (rate_hi),
        .sf_en_i   (sf_en),
        .esf_i     (esf),
        .dbl_i     (dbl),
        .bypass_i  (bypass),
        .byp_fp_i  (byp_fp),
        .fp_o      (fp)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R5";
    bit    fb_en = 1'b0;
    bit    prev_fp = 1'b0;
    bit    prev_byp = 1'b0;
    bit    done = 1'b0;

    // reference model built from the requirements
    int m_cnt, m_sf;
    bit m_rate, m_sfen, m_esf, m_dbl, m_fp;

    function automatic int frame_last(bit r);
        return r ? 255 : 192;
    endfunction

    function automatic int sf_len(bit s, bit e, bit d);
        int b;
        b = s ? (e ? 24 : 12) : 1;
        return d ? 2 * b : b;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_sf = 0; m_fp = 0;
            m_rate = 0; m_sfen = 0; m_esf = 0; m_dbl = 0;
        end else begin
            bit tk;
            int nc;
            if (bypass) begin
                tk = byp_fp;
                nc = 0;
            end else begin
                tk = (m_cnt == frame_last(m_rate));
                nc = sync_in ? 1 : (tk ? 0 : m_cnt + 1);
            end
            m_fp = tk && (m_sf == 0);
            if (tk) begin
                m_sf   = (m_sf >= sf_len(m_sfen, m_esf, m_dbl) - 1) ? 0 : m_sf + 1;
                m_rate = rate_hi; m_sfen = sf_en; m_esf = esf; m_dbl = dbl;
            end
            m_cnt = nc;
        end
    end

    task automatic chk(string req, int act, int exp, string what);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        chk(cur_req, fp, m_fp, "fp_o vs model");
        if (fp && !bypass && !prev_byp) chk("R11", prev_fp, 0, "previous cycle pulse");
        prev_fp  = fp;
        prev_byp = bypass;
        if (fb_en) sync_in = fp;
    endtask

    task automatic wait_pulse(output int gap);
        gap = 0;
        do begin
            step();
            gap++;
        end while (!fp);
    endtask

    task automatic period(string req, int skip, int exp);
        int g;
        cur_req = req;
        repeat (skip) wait_pulse(g);
        wait_pulse(g);
        chk(req, g, exp, "pulse spacing");
    endtask

    task automatic sync_gap(string req, int exp);
        int g;
        cur_req = req;
        g = 0;
        sync_in = 1'b1;
        do begin
            step();
            sync_in = 1'b0;
            g++;
        end while (!(fp && g > 1));
        chk(req, g, exp, "clocks from sync to pulse");
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int g;
        int pulses;
        void'($urandom(32'h5eed_1234));
        rst_n = 0; sync_in = 0; rate_hi = 0; sf_en = 0; esf = 0; dbl = 0;
        bypass = 0; byp_fp = 0;

        // R5: reset state and first pulse
        repeat (3) @(negedge clk);
        chk("R5", fp, 0, "fp_o during reset");
        rst_n = 1;
        cur_req = "R5";
        wait_pulse(g);
        chk("R5", g, 193, "first pulse after reset");

        // R1: free-running short frame
        period("R1", 0, 193);
        period("R1", 0, 193);

        // R2: long frame, latched at the next boundary
        rate_hi = 1;
        period("R2", 1, 256);

        // R3: sync at random offsets
        for (int i = 0; i < 6; i++) begin
            cur_req = "R3";
            repeat (20 + ($urandom % 300)) step();
            sync_gap("R3", 256);
        end

        // R4: output fed back to the sync input
        fb_en = 1'b1;
        for (int i = 0; i < 3; i++) period("R4", 0, 256);
        fb_en = 1'b0;
        sync_in = 0;

        // R6: superframe of 12, then 24
        rate_hi = 0; sf_en = 1;
        period("R6", 3, 12 * 193);
        esf = 1;
        period("R6", 1, 24 * 193);

        // R7: doubled period, frame and superframe
        sf_en = 0; esf = 0; dbl = 1;
        period("R7", 2, 2 * 193);
        sf_en = 1;
        period("R7", 2, 24 * 193);

        // R8: sync does not reset the superframe count
        dbl = 0;
        period("R8", 2, 12 * 193);
        for (int i = 0; i < 3; i++) begin
            cur_req = "R8";
            repeat (2 + ($urandom % 150)) step();
            sync_gap("R8", 12 * 193);
        end

        // back to plain frames
        sf_en = 0;
        period("R1", 2, 193);

        // R9: pass-through, sync noise and counter ignored
        bypass = 1;
        cur_req = "R9";
        pulses = 0;
        for (int i = 0; i < 400; i++) begin
            sync_in = (($urandom % 7) == 0);
            step();
            if (fp) pulses++;
        end
        sync_in = 0;
        chk("R9", pulses, 0, "pulses without pass-through input");
        byp_fp = 1;
        step();
        byp_fp = 0;
        chk("R9", fp, 1, "pass-through pulse one clock later");
        sf_en = 1;
        for (int i = 0; i < 3000; i++) begin
            byp_fp = (($urandom % 20) == 0);
            step();
        end
        byp_fp = 0; sf_en = 0; bypass = 0;
        period("R1", 3, 193);

        // R10: a mode change mid-frame waits for the boundary
        cur_req = "R10";
        repeat (50) step();
        rate_hi = 1;
        wait_pulse(g);
        chk("R10", g, 143, "frame after mid-frame rate change");
        wait_pulse(g);
        chk("R10", g, 256, "frame after latch");

        // mixed random traffic checked against the model
        cur_req = "R10";
        for (int i = 0; i < 20000; i++) begin
            if (($urandom % 600) == 0)  rate_hi = ~rate_hi;
            if (($urandom % 900) == 0)  sf_en = ~sf_en;
            if (($urandom % 900) == 0)  esf = ~esf;
            if (($urandom % 1200) == 0) dbl = ~dbl;
            if (($urandom % 4000) == 0) bypass = ~bypass;
            sync_in = !bypass && (($urandom % 400) == 0);
            byp_fp  = bypass && (($urandom % 30) == 0);
            step();
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule